// File: doc/BRIEF.md
# TLB Replacement Counter Register

This block is a memory-management control register. It decides which unified-TLB entry a software TLB-load operation overwrites. It holds a 6-bit replacement counter that advances once for every unified-TLB access. It also holds a 6-bit replacement boundary. When the boundary is nonzero, the counter wraps back to zero at the boundary instead of running through all 64 entries. The current counter value is presented as the replacement index. The TLB-load operation reads that index, but the operation itself does not move the counter.

The same 32-bit register word carries two mode bits:

- a store-queue access-rights bit, which allows privileged-only access when set;
- a memory-mode bit, which selects multiple virtual memory when 0 and single virtual memory when 1.

It also carries a write-only invalidate bit. Writing a 1 to that bit raises a one-cycle invalidate-all pulse. A write that changes the memory-mode bit without also requesting invalidation sets a sticky error flag. The register is read through a combinational data port and written through a single write strobe.

Top module: `tlb_repl_ctrl`

## Requirements
- R1: After synchronous reset, the read word is 0x00000000, the replacement index is 0, and the mode outputs, the invalidate pulse and the error flag are all 0.
- R2: The boundary is read/write at bits 23:18. The counter is read/write at bits 15:10. The store-queue bit is at bit 9 and the memory-mode bit is at bit 8. Every other bit reads 0, including the invalidate bit 2 and the reserved bits 25:24 and 17:16.
- R3: Each cycle with the access strobe high (and no register write) advances the counter by exactly one. With boundary 0 the counter covers all 64 values, and 0x3F is followed by 0.
- R4: The TLB-load strobe leaves the counter unchanged.
- R5: With a nonzero boundary, an access while the counter equals the boundary sets the counter to 0.
- R6: If the counter is above a nonzero boundary, accesses advance it to 0x3F and then wrap it to 0. After that, the boundary wrap of R5 applies.
- R7: Output sq_priv_only follows bit 9 and output single_vm follows bit 8 of the last write.
- R8: A write with bit 2 set gives an inval_pulse that is high for exactly the one cycle after the write.
- R9: A write that changes bit 8 while bit 2 is 0 sets mode_err. mode_err then stays set until reset.
- R10: When a register write and an access strobe occur in the same cycle, the counter takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| utlb_access | input | 1 | One pulse per unified-TLB access |
| ldtlb_strobe | input | 1 | One pulse per TLB-load operation |
| repl_index | output | 6 | Entry index for the next TLB load |
| sq_priv_only | output | 1 | Store queues restricted to privileged access |
| single_vm | output | 1 | Single virtual memory mode selected |
| inval_pulse | output | 1 | One-cycle invalidate-all request |
| mode_err | output | 1 | Sticky flag: mode changed without invalidate |

## Verification
The bench exercises two same-cycle collisions on the counter.

- **Register write with access:** the bench raises the access strobe in the very cycle that a counter value is written. It then judges the result by the replacement index on the next falling edge, which must equal the written value and not the value plus one.
- **TLB load with access:** the bench raises the TLB-load strobe on its own and also together with an access. A lone load must leave the index unchanged, and a combined load and access must advance it by exactly one.

// File: rtl/tlbrc_pkg.sv
package tlbrc_pkg;

    localparam int REG_W   = 32;
    localparam int CNT_W   = 6;
    localparam int BND_LSB = 18;
    localparam int CNT_LSB = 10;
    localparam int SQ_BIT  = 9;
    localparam int VM_BIT  = 8;
    localparam int INV_BIT = 2;
    localparam int BND_MSB = BND_LSB + CNT_W - 1;
    localparam int CNT_MSB = CNT_LSB + CNT_W - 1;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [REG_W-1:0] word_t;

    typedef struct packed {
        cnt_t bnd;
        cnt_t cnt;
        logic sq_priv;
        logic single_vm;
        logic inval;
    } wr_fields_t;

    typedef struct packed {
        cnt_t bnd;
        cnt_t cnt;
        logic sq_priv;
        logic single_vm;
    } rd_fields_t;

    function automatic wr_fields_t unpack_write(input word_t w);
        wr_fields_t f;
        f.bnd       = w[BND_MSB:BND_LSB];
        f.cnt       = w[CNT_MSB:CNT_LSB];
        f.sq_priv   = w[SQ_BIT];
        f.single_vm = w[VM_BIT];
        f.inval     = w[INV_BIT];
        return f;
    endfunction

    function automatic word_t pack_read(input rd_fields_t f);
        word_t w;
        w                  = '0;
        w[BND_MSB:BND_LSB] = f.bnd;
        w[CNT_MSB:CNT_LSB] = f.cnt;
        w[SQ_BIT]          = f.sq_priv;
        w[VM_BIT]          = f.single_vm;
        return w;
    endfunction

    function automatic cnt_t advance(input cnt_t cnt, input cnt_t bnd);
        if (bnd != '0 && cnt == bnd)
            return '0;
        return cnt + 1'b1;
    endfunction

endpackage

// File: rtl/tlbrc_counter.sv
module tlbrc_counter
    import tlbrc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  cnt_t wr_cnt,
    input  cnt_t wr_bnd,
    input  logic access,
    input  logic ldtlb,
    output cnt_t cnt,
    output cnt_t bnd
);

    cnt_t cnt_q, bnd_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_en)
            cnt_d = wr_cnt;
        else if (access)
            cnt_d = advance(cnt_q, bnd_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            bnd_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (wr_en)
                bnd_q <= wr_bnd;
        end
    end

    assign cnt = cnt_q;
    assign bnd = bnd_q;

    AST_LDTLB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ldtlb && !access && !wr_en) |=> (cnt_q == $past(cnt_q)));   // R4

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (access && !wr_en && !(bnd_q != '0 && cnt_q == bnd_q))
            |=> (cnt_q == cnt_t'($past(cnt_q) + 1'b1)));              // R3

    AST_BOUND_WRAP: assert property (@(posedge clk) disable iff (rst)
        (access && !wr_en && bnd_q != '0 && cnt_q == bnd_q)
            |=> (cnt_q == '0));                                       // R5

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt_q == $past(wr_cnt)));                          // R10

endmodule

// File: rtl/tlbrc_mode.sv
module tlbrc_mode (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_sq,
    input  logic wr_vm,
    input  logic wr_inv,
    output logic sq_priv,
    output logic single_vm,
    output logic inval_pulse,
    output logic mode_err
);

    logic vm_flip_bad;

    assign vm_flip_bad = wr_en && (wr_vm != single_vm) && !wr_inv;

    always_ff @(posedge clk) begin
        if (rst) begin
            sq_priv     <= 1'b0;
            single_vm   <= 1'b0;
            inval_pulse <= 1'b0;
            mode_err    <= 1'b0;
        end else begin
            inval_pulse <= wr_en && wr_inv;
            if (wr_en) begin
                sq_priv   <= wr_sq;
                single_vm <= wr_vm;
            end
            if (vm_flip_bad)
                mode_err <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        mode_err |=> mode_err);                                       // R9

    AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> !inval_pulse);                                   // R8

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> ($stable(sq_priv) && $stable(single_vm)));       // R7

endmodule

// File: rtl/tlb_repl_ctrl.sv
module tlb_repl_ctrl
    import tlbrc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        utlb_access,
    input  logic        ldtlb_strobe,
    output logic [5:0]  repl_index,
    output logic        sq_priv_only,
    output logic        single_vm,
    output logic        inval_pulse,
    output logic        mode_err
);

    wr_fields_t wf;
    rd_fields_t rf;
    cnt_t       cnt, bnd;
    logic       unused_wbits;

    assign wf = unpack_write(reg_wdata);
    assign unused_wbits = ^{reg_wdata[31:BND_MSB+1], reg_wdata[BND_LSB-1:CNT_MSB+1],
                            reg_wdata[VM_BIT-1:INV_BIT+1], reg_wdata[INV_BIT-1:0]};

    tlbrc_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_we),
        .wr_cnt (wf.cnt),
        .wr_bnd (wf.bnd),
        .access (utlb_access),
        .ldtlb  (ldtlb_strobe),
        .cnt    (cnt),
        .bnd    (bnd)
    );

    tlbrc_mode u_mode (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_we),
        .wr_sq       (wf.sq_priv),
        .wr_vm       (wf.single_vm),
        .wr_inv      (wf.inval),
        .sq_priv     (sq_priv_only),
        .single_vm   (single_vm),
        .inval_pulse (inval_pulse),
        .mode_err    (mode_err)
    );

    always_comb begin
        rf.bnd       = bnd;
        rf.cnt       = cnt;
        rf.sq_priv   = sq_priv_only;
        rf.single_vm = single_vm;
        reg_rdata    = pack_read(rf);
    end

    assign repl_index = cnt;

    AST_INDEX_MATCHES_READ: assert property (@(posedge clk) disable iff (rst)
        repl_index == reg_rdata[CNT_MSB:CNT_LSB]);                    // R2

    AST_INVAL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[INV_BIT] == 1'b0);                                  // R2

endmodule

// File: tb/tlb_repl_ctrl_test.sv
module tlb_repl_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        utlb_access = 1'b0;
    logic        ldtlb_strobe = 1'b0;
    logic [5:0]  repl_index;
    logic        sq_priv_only, single_vm, inval_pulse, mode_err;

    int checks = 0;
    int errors = 0;
    logic pulse_seen;

    always #5 clk = ~clk;

    tlb_repl_ctrl uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .utlb_access(utlb_access),
        .ldtlb_strobe(ldtlb_strobe), .repl_index(repl_index),
        .sq_priv_only(sq_priv_only), .single_vm(single_vm),
        .inval_pulse(inval_pulse), .mode_err(mode_err)
    );

    function automatic logic [31:0] word(input logic [5:0] b, input logic [5:0] c,
                                         input logic sq, input logic vm, input logic inv);
        return {8'h00, b, 2'b00, c, sq, vm, 5'b0, inv, 2'b00};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        pulse_seen = inval_pulse;
    endtask

    task automatic acc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            utlb_access = 1'b1;
        end
        @(negedge clk);
        utlb_access = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 index", {26'b0, repl_index}, 32'h0);
        check("R1 outs", {28'b0, sq_priv_only, single_vm, inval_pulse, mode_err}, 32'h0);
    endtask

    task automatic t_fields;
        wr(32'hFFFF_FFFF);
        check("R2 readback mask", reg_rdata, 32'h00FC_FF00);
        check("R7 sq/vm outs", {30'b0, sq_priv_only, single_vm}, 32'h3);
        wr(word(6'd0, 6'd0, 1'b1, 1'b0, 1'b1));
        check("R7 sq only", {30'b0, sq_priv_only, single_vm}, 32'h2);
        check("R2 bit2 reads 0", reg_rdata, 32'h0000_0200);
    endtask

    task automatic t_free_run;
        wr(word(6'd0, 6'h3E, 1'b0, 1'b0, 1'b0));
        acc(1);
        check("R3 step to 3F", {26'b0, repl_index}, 32'h3F);
        acc(1);
        check("R3 wrap 3F to 0", {26'b0, repl_index}, 32'h0);
        acc(5);
        check("R3 five steps", {26'b0, repl_index}, 32'h5);
    endtask

    task automatic t_ldtlb;
        @(negedge clk); ldtlb_strobe = 1'b1;
        @(negedge clk); ldtlb_strobe = 1'b0;
        check("R4 ldtlb alone", {26'b0, repl_index}, 32'h5);
        @(negedge clk); ldtlb_strobe = 1'b1; utlb_access = 1'b1;
        @(negedge clk); ldtlb_strobe = 1'b0; utlb_access = 1'b0;
        check("R4 ldtlb with access", {26'b0, repl_index}, 32'h6);
    endtask

    task automatic t_boundary;
        wr(word(6'd5, 6'd3, 1'b0, 1'b0, 1'b0));
        acc(2);
        check("R5 reach boundary", {26'b0, repl_index}, 32'h5);
        acc(1);
        check("R5 clear at boundary", {26'b0, repl_index}, 32'h0);
        acc(6);
        check("R5 second lap", {26'b0, repl_index}, 32'h0);
    endtask

    task automatic t_above;
        wr(word(6'd4, 6'h3D, 1'b0, 1'b0, 1'b0));
        acc(1);
        check("R6 past boundary", {26'b0, repl_index}, 32'h3E);
        acc(1);
        check("R6 reach 3F", {26'b0, repl_index}, 32'h3F);
        acc(1);
        check("R6 wrap to 0", {26'b0, repl_index}, 32'h0);
        acc(4);
        check("R6 at boundary", {26'b0, repl_index}, 32'h4);
        acc(1);
        check("R6 boundary rule resumes", {26'b0, repl_index}, 32'h0);
    endtask

    task automatic t_collision;
        @(negedge clk);
        reg_we = 1'b1; utlb_access = 1'b1;
        reg_wdata = word(6'd0, 6'h10, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        reg_we = 1'b0; utlb_access = 1'b0;
        check("R10 write beats access", {26'b0, repl_index}, 32'h10);
    endtask

    task automatic t_inval;
        wr(word(6'd0, 6'd0, 1'b0, 1'b1, 1'b1));
        check("R8 pulse high", {31'b0, pulse_seen}, 32'h1);
        check("R9 no err with inval", {31'b0, mode_err}, 32'h0);
        @(negedge clk);
        check("R8 pulse one cycle", {31'b0, inval_pulse}, 32'h0);
        wr(word(6'd0, 6'd0, 1'b0, 1'b1, 1'b0));
        check("R8 no pulse without bit2", {31'b0, pulse_seen}, 32'h0);
        check("R9 same vm no err", {31'b0, mode_err}, 32'h0);
    endtask

    task automatic t_err;
        wr(word(6'd0, 6'd0, 1'b0, 1'b0, 1'b0));
        check("R9 err set", {31'b0, mode_err}, 32'h1);
        wr(word(6'd0, 6'd0, 1'b0, 1'b0, 1'b1));
        acc(2);
        check("R9 err sticky", {31'b0, mode_err}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fields();
        t_free_run();
        t_ldtlb();
        t_boundary();
        t_above();
        t_collision();
        t_inval();
        t_err();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule